// File: doc/BRIEF.md
# Calibrated ADC-Code to Temperature Converter

This block turns a raw sensor ADC code into a signed temperature in millidegrees Celsius. It holds a calibration curve of (code, temperature) points as constants computed at elaboration time. Codes rise strictly with temperature, and the curve runs from -40000 to 125000 millidegrees. For an accepted code, a sequential binary search finds the pair of neighbouring points that bracket the code. The block then interpolates linearly between those two points. A shift-add multiplier and a restoring divider produce the fraction over many cycles.

A code arrives on a valid/ready handshake. The block takes one code at a time. It holds its ready low while the conversion runs and raises ready again in the cycle that its one-cycle result strobe appears. A code that falls outside the calibrated span saturates to the hottest value, so that a broken or disconnected sensor reads as too hot.

Top module: `tinterp_top`

## Requirements
- R1: Calibration point i (0 ≤ i < DEPTH, DEPTH = 36 by default) has code 30 + 18·i + floor(i·i/4) and temperature -40000 + floor(165000·i/(DEPTH-1)). Codes strictly increase, and temperatures run from -40000 to 125000.
- R2: A code is accepted on a rising clock edge where inValid and inReady are both high. inReady is high only while the block is idle. inReady is low in the cycle after an acceptance and stays low until the cycle in which outValid pulses.
- R3: A code below the code of point 0, or above the code of the last point, gives 125000. outValid pulses two clock edges after the acceptance edge.
- R4: A code equal to the code of point 0 gives the temperature of point 0 (-40000) exactly, two clock edges after acceptance, without interpolation.
- R5: A code equal to the code of any point i ≥ 1 gives the temperature of point i exactly.
- R6: For a code with code(i-1) < code < code(i), the result is temp(i-1) + floor((temp(i)-temp(i-1))·(code-code(i-1)) / (code(i)-code(i-1))).
- R7: Each accepted code produces exactly one outValid pulse, one cycle wide, and results come out in acceptance order. outTemp keeps its value until the next pulse.
- R8: While rstN is low, inReady is high, outValid is low and outTemp is 0.
- R9: Every result lies in [-40000, 125000]. Within the calibrated span, the result never decreases as the code increases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A code is offered on inCode |
| inReady | output | 1 | The block is idle and takes the offered code |
| inCode | input | CODE_W (10) | Raw ADC code |
| outValid | output | 1 | One-cycle strobe: outTemp holds a new result |
| outTemp | output | TEMP_W (32) | Signed temperature in millidegrees |

## Verification
The conversion is exercised with codes below and above the calibrated span, which separate saturation from interpolation. It is also exercised with the exact code of point 0, which checks the early exit, and with the exact code of every interior point, which checks that interpolation lands on the point itself. An exhaustive sweep over all 1024 codes compares each result with a linear-scan reference. That sweep catches search errors that pick the wrong bracket, truncation errors in the divider, and any non-monotonic step between neighbouring codes. Checks on the handshake and on the result holding its value show whether results are lost, duplicated or reordered.

// File: rtl/tinterp_pkg.sv
package tinterp_pkg;

  localparam int TEMP_LO   = -40000;
  localparam int TEMP_HI   = 125000;
  localparam int TEMP_SPAN = TEMP_HI - TEMP_LO;

  // Strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic load;
    logic takeSat;
    logic takeFirst;
    logic srchStep;
    logic mulInit;
    logic mulStep;
    logic divInit;
    logic divStep;
    logic finish;
  } ctlStrobe_t;

  // Conditions reported by the datapath to the control FSM
  typedef struct packed {
    logic rangeOut;
    logic firstHit;
    logic bracketHit;
    logic mulLast;
    logic divLast;
  } dpStatus_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_SEARCH, ST_MULLD, ST_MUL, ST_DIVLD, ST_DIV, ST_DONE
  } ctlState_t;

  // Calibration curve: code grows slightly faster than linearly (R1)
  function automatic int calCode(int i);
    return 30 + 18 * i + (i * i) / 4;
  endfunction

  function automatic int calTemp(int i, int depth);
    return TEMP_LO + (TEMP_SPAN * i) / (depth - 1);
  endfunction

endpackage

// File: rtl/tinterp_ctrl.sv
module tinterp_ctrl
  import tinterp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe
);

  ctlState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (inValid) begin
          strobe.load = 1'b1;
          stateD      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.rangeOut) begin
          strobe.takeSat = 1'b1;
          stateD         = ST_IDLE;
        end else if (status.firstHit) begin
          strobe.takeFirst = 1'b1;
          stateD           = ST_IDLE;
        end else begin
          stateD = ST_SEARCH;
        end
      end
      ST_SEARCH: begin
        strobe.srchStep = 1'b1;
        if (status.bracketHit) stateD = ST_MULLD;
      end
      ST_MULLD: begin
        strobe.mulInit = 1'b1;
        stateD         = ST_MUL;
      end
      ST_MUL: begin
        strobe.mulStep = 1'b1;
        if (status.mulLast) stateD = ST_DIVLD;
      end
      ST_DIVLD: begin
        strobe.divInit = 1'b1;
        stateD         = ST_DIV;
      end
      ST_DIV: begin
        strobe.divStep = 1'b1;
        if (status.divLast) stateD = ST_DONE;
      end
      ST_DONE: begin
        strobe.finish = 1'b1;
        stateD        = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign inReady = (stateQ == ST_IDLE);

endmodule

// File: rtl/tinterp_datapath.sv
module tinterp_datapath
  import tinterp_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int DEPTH  = 36,
  parameter int TEMP_W = 32,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CODE_W-1:0]        inCode,
  input  ctlStrobe_t               strobe,
  output dpStatus_t                status,
  output logic                     outValid,
  output logic signed [TEMP_W-1:0] outTemp
);

  localparam int IW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(ACC_W);

  // Calibration constants, one entry per point
  logic [CODE_W-1:0]        codeRom [DEPTH];
  logic signed [TEMP_W-1:0] tempRom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gRom
    assign codeRom[g] = CODE_W'(calCode(g));
    assign tempRom[g] = TEMP_W'(calTemp(g, DEPTH));
  end

  logic [CODE_W-1:0] codeQ;
  logic [IW-1:0]     lowQ, highQ, idxQ;
  logic [ACC_W-1:0]  mcandQ, accQ, remQ, quoQ, divisorQ;
  logic [CODE_W-1:0] mplierQ;
  logic [CNT_W-1:0]  cntQ;

  // Search probe
  logic [IW-1:0] midIdx, midLow;
  logic          goUp;
  assign midIdx = IW'(({1'b0, lowQ} + {1'b0, highQ}) >> 1);
  assign midLow = (midIdx == '0) ? '0 : midIdx - IW'(1);
  assign goUp   = codeQ > codeRom[midIdx];

  // Bracket operands
  logic [IW-1:0]            idxLow;
  logic signed [TEMP_W-1:0] dTemp;
  logic [CODE_W-1:0]        dCode, offs;
  assign idxLow = idxQ - IW'(1);
  assign dTemp  = tempRom[idxQ] - tempRom[idxLow];
  assign dCode  = codeRom[idxQ] - codeRom[idxLow];
  assign offs   = codeQ - codeRom[idxLow];

  // Restoring divider trial subtraction
  logic [ACC_W-1:0] remShift;
  logic             fits;
  assign remShift = {remQ[ACC_W-2:0], quoQ[ACC_W-1]};
  assign fits     = remShift >= divisorQ;

  assign status.rangeOut   = (codeQ < codeRom[0]) || (codeQ > codeRom[DEPTH-1]);
  assign status.firstHit   = (codeQ == codeRom[0]);
  assign status.bracketHit = (midIdx != '0) && (codeQ > codeRom[midLow]) &&
                             (codeQ <= codeRom[midIdx]);
  assign status.mulLast    = (cntQ == CNT_W'(CODE_W - 1));
  assign status.divLast    = (cntQ == CNT_W'(ACC_W - 1));

  // Search registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
      lowQ  <= '0;
      highQ <= '0;
      idxQ  <= '0;
    end else if (strobe.load) begin
      codeQ <= inCode;
      lowQ  <= '0;
      highQ <= IW'(DEPTH - 1);
    end else if (strobe.srchStep) begin
      if (status.bracketHit) idxQ  <= midIdx;
      else if (goUp)         lowQ  <= midIdx + IW'(1);
      else                   highQ <= midIdx - IW'(1);
    end
  end

  // Shift-add multiplier and restoring divider share one step counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandQ   <= '0;
      mplierQ  <= '0;
      accQ     <= '0;
      remQ     <= '0;
      quoQ     <= '0;
      divisorQ <= '0;
      cntQ     <= '0;
    end else if (strobe.mulInit) begin
      mcandQ  <= ACC_W'($unsigned(dTemp));
      mplierQ <= offs;
      accQ    <= '0;
      cntQ    <= '0;
    end else if (strobe.mulStep) begin
      if (mplierQ[0]) accQ <= accQ + mcandQ;
      mcandQ  <= mcandQ << 1;
      mplierQ <= mplierQ >> 1;
      cntQ    <= cntQ + CNT_W'(1);
    end else if (strobe.divInit) begin
      quoQ     <= accQ;
      remQ     <= '0;
      divisorQ <= ACC_W'(dCode);
      cntQ     <= '0;
    end else if (strobe.divStep) begin
      remQ <= fits ? remShift - divisorQ : remShift;
      quoQ <= {quoQ[ACC_W-2:0], fits};
      cntQ <= cntQ + CNT_W'(1);
    end
  end

  // Result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outTemp  <= '0;
    end else begin
      outValid <= strobe.takeSat | strobe.takeFirst | strobe.finish;
      if (strobe.takeSat)        outTemp <= TEMP_W'(TEMP_HI);
      else if (strobe.takeFirst) outTemp <= tempRom[0];
      else if (strobe.finish)    outTemp <= tempRom[idxLow] + $signed(TEMP_W'(quoQ));
    end
  end

endmodule

// File: rtl/tinterp_top.sv
module tinterp_top
  import tinterp_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int DEPTH  = 36,
  parameter int TEMP_W = 32,
  parameter int ACC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [CODE_W-1:0]        inCode,
  output logic                     outValid,
  output logic signed [TEMP_W-1:0] outTemp
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  tinterp_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .status  (status),
    .strobe  (strobe)
  );

  tinterp_datapath #(
    .CODE_W (CODE_W),
    .DEPTH  (DEPTH),
    .TEMP_W (TEMP_W),
    .ACC_W  (ACC_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .inCode   (inCode),
    .strobe   (strobe),
    .status   (status),
    .outValid (outValid),
    .outTemp  (outTemp)
  );

endmodule

// File: rtl/tinterp_checker.sv
module tinterp_checker
  import tinterp_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int DEPTH  = 36,
  parameter int TEMP_W = 32
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic                     inReady,
  input logic [CODE_W-1:0]        inCode,
  input logic                     outValid,
  input logic signed [TEMP_W-1:0] outTemp
);

  localparam int CMIN   = calCode(0);
  localparam int CMAX   = calCode(DEPTH - 1);
  localparam int TFIRST = calTemp(0, DEPTH);

  logic accept;
  assign accept = inValid && inReady;

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !inReady);

  a_r3_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (accept && ((int'(inCode) < CMIN) || (int'(inCode) > CMAX)))
      |=> ##1 (outValid && (outTemp == TEMP_W'(TEMP_HI))));

  a_r4_first_exact: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (int'(inCode) == CMIN))
      |=> ##1 (outValid && (outTemp == TEMP_W'(TFIRST))));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r7_ready_with_result: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outTemp));

  a_r9_bounds: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outTemp >= TEMP_W'(TEMP_LO)) && (outTemp <= TEMP_W'(TEMP_HI))));

endmodule

bind tinterp_top tinterp_checker #(
  .CODE_W (CODE_W),
  .DEPTH  (DEPTH),
  .TEMP_W (TEMP_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inCode   (inCode),
  .outValid (outValid),
  .outTemp  (outTemp)
);

// File: tb/tinterp_top_bench.sv
module tinterp_top_bench;

  localparam int CODE_W = 10;
  localparam int DEPTH  = 36;
  localparam int TEMP_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [CODE_W-1:0] inCode = '0;
  logic inReady, outValid;
  logic signed [TEMP_W-1:0] outTemp;

  int errors = 0;
  int checks = 0;
  int expQ[$];
  int codeQ[$];
  int lastExp = 0;
  int lastCode = -10;
  int lastTemp = 0;
  bit prevValid = 1'b0;

  tinterp_top #(.CODE_W(CODE_W), .DEPTH(DEPTH), .TEMP_W(TEMP_W)) u_tinterp_top (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inCode(inCode), .outValid(outValid), .outTemp(outTemp)
  );

  always #2 clk = ~clk;

  // Reference model written from R1 and R3..R6 (linear scan)
  function automatic int refCode(int i);
    return 30 + 18 * i + (i * i) / 4;
  endfunction
  function automatic int refTemp(int i);
    return -40000 + (165000 * i) / (DEPTH - 1);
  endfunction
  function automatic int refConvert(int c);
    if (c < refCode(0) || c > refCode(DEPTH - 1)) return 125000;
    if (c == refCode(0)) return refTemp(0);
    for (int i = 1; i < DEPTH; i++)
      if (c <= refCode(i))
        return refTemp(i - 1) + ((refTemp(i) - refTemp(i - 1)) * (c - refCode(i - 1))) /
               (refCode(i) - refCode(i - 1));
    return 125000;
  endfunction
  function automatic string reqOf(int c);
    if (c < refCode(0) || c > refCode(DEPTH - 1)) return "R3";
    if (c == refCode(0)) return "R4";
    for (int i = 1; i < DEPTH; i++) if (c == refCode(i)) return "R5";
    return "R6";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Driver: offer one code, push its expected result
  task automatic sendCode(int c, bit checkBusy);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inCode  = CODE_W'(c);
    expQ.push_back(refConvert(c));
    codeQ.push_back(c);
    @(negedge clk);
    inValid = 1'b0;
    if (checkBusy) check(inReady == 1'b0, "R2", "ready after accept", int'(inReady), 0);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    int e;
    int c;
    if (rstN) begin
      if (outValid) begin
        if (prevValid) check(1'b0, "R7", "back-to-back valid", 1, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected result", outTemp, 0);
        end else begin
          e = expQ.pop_front();
          c = codeQ.pop_front();
          check(outTemp == e, reqOf(c), $sformatf("code %0d", c), outTemp, e);
          check(outTemp >= -40000 && outTemp <= 125000, "R9", "bounds", outTemp, e);
          if (c == lastCode + 1 && c > refCode(0) && c <= refCode(DEPTH - 1))
            check(outTemp >= lastTemp, "R9", "monotonic", outTemp, lastTemp);
          lastExp  = e;
          lastCode = c;
          lastTemp = outTemp;
        end
      end
      prevValid = outValid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(inReady == 1'b1, "R8", "reset inReady", int'(inReady), 1);
    check(outValid == 1'b0, "R8", "reset outValid", int'(outValid), 0);
    check(outTemp == 0, "R8", "reset outTemp", outTemp, 0);
    rstN = 1'b1;

    // R3 saturation at both ends, R2 busy after accept
    sendCode(0, 1'b1);
    sendCode(refCode(0) - 1, 1'b1);
    sendCode(refCode(DEPTH - 1) + 1, 1'b1);
    sendCode(1023, 1'b1);
    // R4 exact first point, R6 just above it
    sendCode(refCode(0), 1'b1);
    sendCode(refCode(0) + 1, 1'b1);
    // R5 every interior point exactly, R1 endpoint temperature
    for (int i = 1; i < DEPTH; i++) sendCode(refCode(i), 1'b0);
    // R6 midway between neighbours
    for (int i = 1; i < DEPTH; i++) sendCode((refCode(i - 1) + refCode(i)) / 2 + 1, 1'b0);

    while (expQ.size() != 0) @(negedge clk);
    // R7 hold after a result
    repeat (5) @(negedge clk);
    check(outTemp == lastExp, "R7", "hold between results", outTemp, lastExp);
    check(refTemp(DEPTH - 1) == 125000, "R1", "last point temperature", refTemp(DEPTH - 1), 125000);

    // R9 exhaustive sweep
    lastCode = -10;
    for (int c = 0; c < (1 << CODE_W); c++) sendCode(c, 1'b0);
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run timed out", 0, 1);
    summary();
    $finish;
  end

endmodule